// File: doc/BRIEF.md
# Trace Word Unpacker

The unpacker takes 32-bit words fetched from an on-chip trace store and splits each one into a stream of per-cycle trace records. Each record carries a 3-bit pipeline status, a packet field of up to 16 bits, a sync flag and a trigger flag. The number of records in a word and where each field sits depend on the width of the trace port that captured the data. A 4-bit port packs three records into a word, an 8-bit port packs two, and a 16-bit port packs one.

Words arrive on a valid/ready handshake. Records leave on a second valid/ready handshake, one per cycle while the consumer is ready, lowest record first. The port width is sampled together with each word.

Capture hardware marks a trigger by writing a reserved code into the status field. When the unpacker sees that code, it takes the real status from the three low packet bits and raises the trigger flag. The unpacker does not interpret status values in any other way.

Top module: `trc_unpacker`

## Requirements
- R1: After reset `rec_valid` is 0 and `in_ready` is 1.
- R2: With `port_mode` 0 (4-bit port), a word yields three records. Each record occupies 8 bits: status in bits 2:0, packet in bits 6:3 and sync in bit 7. The three records start at word bits 0, 8 and 16. Bits 31:24 have no effect on any record.
- R3: With `port_mode` 1 (8-bit port), a word yields two records. The first has status in bits 2:0, packet in bits 10:3 and sync in bit 11. The second has status in bits 14:12, packet in bits 22:15 and sync in bit 23.
- R4: With `port_mode` 2 or 3 (16-bit port), a word yields one record with status in bits 2:0, packet in bits 18:3 and sync in bit 19.
- R5: When a record's raw status equals `TRIG_CODE` (default 6), `rec_status` is the record's packet bits 2:0 and `rec_trig` is 1. Otherwise `rec_status` is the raw status and `rec_trig` is 0.
- R6: Records leave lowest first, one per cycle while `rec_ready` is high. `rec_valid` rises in the cycle after a word is accepted.
- R7: While `rec_valid` is high and `rec_ready` is low, every record output holds its value.
- R8: A word is accepted only when no record is pending, or in the same cycle that the word's last record is taken. `in_ready` is low at all other times.
- R9: `port_mode` is sampled only when a word is accepted. Changing it while records are pending has no effect on them.
- R10: Packet bits above the width the port carries (bits 15:4 in 4-bit mode, bits 15:8 in 8-bit mode) read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_mode | input | 2 | Trace port width: 0 = 4-bit, 1 = 8-bit, 2 or 3 = 16-bit |
| in_word | input | 32 | Trace word from the buffer |
| in_valid | input | 1 | `in_word` is valid |
| in_ready | output | 1 | Unpacker accepts a word this cycle |
| rec_valid | output | 1 | A record is presented |
| rec_ready | input | 1 | Consumer takes the record |
| rec_status | output | 3 | Pipeline status, with the trigger substitution applied |
| rec_packet | output | 16 | Packet field, zero-extended |
| rec_sync | output | 1 | Sync flag |
| rec_trig | output | 1 | Record carried the trigger code |

## Verification
The bench builds the unpacker with the default trigger code of 6. Test words place 6 in some status fields and nearby codes such as 7 in others, so the bench can tell a substituted status apart from a raw one. The bench also picks packet low bits that differ from the trigger code, so a substitution that does not happen shows up as a wrong status.

Every port width is exercised, including mode code 3 as a 16-bit alias. Words with bits 31:24 set are used in 4-bit mode to confirm those bits stay out of the records. The bench also covers stalled consumers, a change of `port_mode` while records are pending, and a back-to-back word accepted in the same cycle as the last record is taken.

// File: rtl/trc_unpacker.sv
module trc_unpacker #(
  parameter logic [2:0] TRIG_CODE = 3'd6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  port_mode,
  input  logic [31:0] in_word,
  input  logic        in_valid,
  output logic        in_ready,
  output logic        rec_valid,
  input  logic        rec_ready,
  output logic [2:0]  rec_status,
  output logic [15:0] rec_packet,
  output logic        rec_sync,
  output logic        rec_trig
);
  localparam int STEP_NARROW = 8;
  localparam int STEP_MID    = 12;

  logic [31:0] word_q;
  logic [1:0]  mode_q, left_q;
  logic        last, take_in, take_rec, hit;
  logic [2:0]  raw_status;

  function automatic logic [1:0] recs_per_word(input logic [1:0] m);
    case (m)
      2'd0:    return 2'd3;
      2'd1:    return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

  assign last      = (left_q == 2'd1);
  assign rec_valid = (left_q != 2'd0);
  assign in_ready  = !rec_valid || (rec_ready && last);
  assign take_in   = in_valid && in_ready;
  assign take_rec  = rec_valid && rec_ready;

  always_comb begin
    raw_status = word_q[2:0];
    case (mode_q)
      2'd0: begin
        rec_packet = {12'd0, word_q[6:3]};
        rec_sync   = word_q[7];
      end
      2'd1: begin
        rec_packet = {8'd0, word_q[10:3]};
        rec_sync   = word_q[11];
      end
      default: begin
        rec_packet = word_q[18:3];
        rec_sync   = word_q[19];
      end
    endcase
    hit        = (raw_status == TRIG_CODE);
    rec_trig   = hit;
    rec_status = hit ? rec_packet[2:0] : raw_status;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      mode_q <= 2'd0;
      left_q <= 2'd0;
    end else if (take_in) begin
      word_q <= in_word;
      mode_q <= port_mode;
      left_q <= recs_per_word(port_mode);
    end else if (take_rec) begin
      word_q <= (mode_q == 2'd0) ? (word_q >> STEP_NARROW) : (word_q >> STEP_MID);
      left_q <= left_q - 2'd1;
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_status) && $stable(rec_packet)
                                && $stable(rec_sync) && $stable(rec_trig));

  assert_no_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |-> !in_ready);

  assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_rec && last && !in_valid |=> !rec_valid && in_ready);

  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_in |=> rec_valid);

  assert_mode_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !take_in |=> $stable(mode_q));
endmodule

// File: tb/sim_trc_unpacker.sv
module sim_trc_unpacker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  port_mode = 2'd0;
  logic [31:0] in_word = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        rec_valid;
  logic        rec_ready = 1'b0;
  logic [2:0]  rec_status;
  logic [15:0] rec_packet;
  logic        rec_sync;
  logic        rec_trig;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trc_unpacker u0 (
    .clk(clk), .rst_n(rst_n), .port_mode(port_mode), .in_word(in_word),
    .in_valid(in_valid), .in_ready(in_ready), .rec_valid(rec_valid),
    .rec_ready(rec_ready), .rec_status(rec_status), .rec_packet(rec_packet),
    .rec_sync(rec_sync), .rec_trig(rec_trig)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [20:0] expect_rec(input logic [31:0] w, input logic [1:0] m, input int idx);
    logic [2:0] st; logic [15:0] pk; logic sy, tr;
    int b;
    if (m == 2'd0) begin
      b = idx * 8; st = w[b +: 3]; pk = {12'd0, w[b + 3 +: 4]}; sy = w[b + 7];
    end else if (m == 2'd1) begin
      b = idx * 12; st = w[b +: 3]; pk = {8'd0, w[b + 3 +: 8]}; sy = w[b + 11];
    end else begin
      st = w[2:0]; pk = w[18:3]; sy = w[19];
    end
    tr = (st == 3'd6);
    if (tr) st = pk[2:0];
    return {tr, sy, pk, st};
  endfunction

  task automatic check_rec(input string tag, input logic [31:0] w, input logic [1:0] m, input int idx);
    logic [20:0] e;
    e = expect_rec(w, m, idx);
    chk({tag, " valid"}, rec_valid, 1'b1);
    chk({tag, " status R5"}, rec_status, e[2:0]);
    chk({tag, " packet R10"}, rec_packet, e[18:3]);
    chk({tag, " sync"}, rec_sync, e[19]);
    chk({tag, " trig R5"}, rec_trig, e[20]);
  endtask

  task automatic run_word(input string tag, input logic [31:0] w, input logic [1:0] m, input int n);
    @(negedge clk);
    chk({tag, " ready before R8"}, in_ready, 1'b1);
    in_word = w; port_mode = m; in_valid = 1'b1; rec_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; port_mode = ~m;
    for (int i = 0; i < n; i++) begin
      check_rec($sformatf("%s rec%0d R6", tag, i), w, m, i);
      @(negedge clk);
    end
    chk({tag, " drained R6"}, rec_valid, 1'b0);
    chk({tag, " ready after R8"}, in_ready, 1'b1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("reset rec_valid R1", rec_valid, 1'b0);
    chk("reset in_ready R1", in_ready, 1'b1);
  endtask

  task automatic t_four_bit;
    run_word("R2 plain", 32'h00_A5_3C_71, 2'd0, 3);
    run_word("R2 trig", 32'hFF_0E_96_87, 2'd0, 3);
    run_word("R2 high bits", 32'hFF_00_00_00, 2'd0, 3);
  endtask

  task automatic t_eight_bit;
    run_word("R3 plain", 32'h00_AB_C1_23, 2'd1, 2);
    run_word("R3 trig", 32'h00_5E_60_4E, 2'd1, 2);
  endtask

  task automatic t_sixteen_bit;
    run_word("R4 mode2", 32'h000F_FFF5, 2'd2, 1);
    run_word("R4 mode3 trig", 32'hFFF8_002E, 2'd3, 1);
  endtask

  task automatic t_stall;
    logic [31:0] w = 32'h00_17_2E_8B;
    @(negedge clk);
    in_word = w; port_mode = 2'd0; in_valid = 1'b1; rec_ready = 1'b0;
    @(negedge clk);
    port_mode = 2'd2;
    chk("stall in_ready low R8", in_ready, 1'b0);
    check_rec("stall first R7", w, 2'd0, 0);
    repeat (3) @(negedge clk);
    check_rec("stall held R7", w, 2'd0, 0);
    chk("stall still blocked R8", in_ready, 1'b0);
    in_valid = 1'b0; rec_ready = 1'b1;
    @(negedge clk);
    check_rec("stall mode kept R9", w, 2'd0, 1);
    @(negedge clk);
    check_rec("stall third R9", w, 2'd0, 2);
    @(negedge clk);
    chk("stall drained R6", rec_valid, 1'b0);
  endtask

  task automatic t_back_to_back;
    logic [31:0] a = 32'h0001_2345;
    logic [31:0] b = 32'h00_99_88_77;
    @(negedge clk);
    in_word = a; port_mode = 2'd2; in_valid = 1'b1; rec_ready = 1'b1;
    @(negedge clk);
    in_word = b; port_mode = 2'd1;
    check_rec("b2b first word R6", a, 2'd2, 0);
    chk("b2b ready on last R8", in_ready, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    check_rec("b2b second word rec0 R8", b, 2'd1, 0);
    @(negedge clk);
    check_rec("b2b second word rec1 R3", b, 2'd1, 1);
    @(negedge clk);
    chk("b2b drained R6", rec_valid, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_four_bit();
    t_eight_bit();
    t_sixteen_bit();
    t_stall();
    t_back_to_back();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule